// File: doc/BRIEF.md
# Serial Conversion Result Read Port

This block is the read side of a converter's serial interface when the host supplies the clock. The host pulls an active-low read frame signal low and then toggles a serial clock. On each rising clock edge the block launches the next bit of a 16-bit word, and the host samples that bit on the following falling edge. The word starts with a zero. Three channel address bits follow, and the 12-bit conversion result comes last, most significant bit first. The block also drives an enable that tells the pad when to leave high impedance.

The host may pause the serial clock at any point, for example to read the word one byte at a time. The output register stays fixed for the length of a read. A result that arrives in the middle of a read is parked and is copied into the output register only after the frame ends. The serial clock and frame inputs are asynchronous. A synchroniser chain running on a system clock at least four times the serial clock rate brings them into that domain, and edge detection happens there.

Top module: `result_serial_port`

## Requirements
- R1: After reset, `sdo_oe` is 0 and the output register holds zero, so the first read returns the address bits followed by a zero result.
- R2: The word is, in time order: one 0 bit, `chan_sel` from MSB to LSB, then the output register from MSB to LSB. With the default widths this is `{1'b0, chan_sel[2:0], result[11:0]}`, sent from bit 15 down to bit 0.
- R3: `sdo` changes only after a rising `sclk` edge. It holds its value through the following low phase, so a bit is still valid at the falling edge and right up to the next rise.
- R4: If `rd_frame_n` falls while `sclk` is high, the leading zero is driven with `sdo_oe` = 1 before any rising `sclk` edge.
- R5: If `rd_frame_n` falls while `sclk` is low, `sdo_oe` stays 0 until the next rising `sclk` edge, and the leading zero is driven from that edge.
- R6: Pauses of any length between serial clock edges inside a frame leave the bit sequence unchanged.
- R7: A rising `sclk` edge after the last bit of the word sets `sdo_oe` to 0 for the rest of the frame. The word is not repeated.
- R8: When `rd_frame_n` is high, `sdo_oe` is 0. This includes a frame that ends early, part way through the word.
- R9: A `conv_valid` pulse while no frame is active loads `conv_data` into the output register at once.
- R10: A `conv_valid` pulse during a frame leaves the output register unchanged until `rd_frame_n` returns high. The pending value is loaded only then.
- R11: If several `conv_valid` pulses arrive during one frame, only the last one's data is loaded when the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock (asynchronous) |
| rd_frame_n | input | 1 | Active-low read frame (asynchronous) |
| conv_valid | input | 1 | One-cycle strobe: a new result is on `conv_data` |
| conv_data | input | RES_W (12) | New conversion result |
| chan_sel | input | ADDR_W (3) | Channel address placed in the word |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
The bench keeps the default 3-bit address and 12-bit result, so each frame is 16 bits. It builds the block with `SYNC_STAGES` = 3 rather than the default 2. Each serial clock half period lasts six system clocks, so the extra synchroniser stage uses up most of the latency margin. This brings within reach the start-phase decision for the leading bit and the early-end case, where the frame and clock edges land close together. Random channel addresses, start phases, clock gaps and mid-frame result strobes are mixed with directed reads after reset, after a deferred update and after a frame cut short.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // Frame sequencing states
  typedef enum logic [1:0] {
    PH_IDLE,   // no frame
    PH_ARMED,  // frame open, waiting for first rising clock
    PH_SHIFT,  // bits are being driven
    PH_DONE    // word exhausted, output parked
  } phase_t;

  function automatic int frame_bits(input int addr_w, input int res_w);
    return 1 + addr_w + res_w;
  endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[b]}};
        prev  <= RST_VAL[b];
      end else begin
        chain[0] <= async_in[b];
        for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        prev <= chain[STAGES-1];
      end
    end

    assign level[b] = chain[STAGES-1];
    assign rise[b]  = chain[STAGES-1] & ~prev;
    assign fall[b]  = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/srp_result_hold.sv
module srp_result_hold #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_valid,
  input  logic [RES_W-1:0] conv_data,
  input  logic             frame_active,
  output logic [RES_W-1:0] out_reg,
  output logic             pend_valid
);

  logic [RES_W-1:0] pend_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_reg    <= '0;
      pend_val   <= '0;
      pend_valid <= 1'b0;
    end else if (conv_valid && !frame_active) begin
      out_reg    <= conv_data;
      pend_valid <= 1'b0;
    end else if (conv_valid) begin
      pend_val   <= conv_data;
      pend_valid <= 1'b1;
    end else if (!frame_active && pend_valid) begin
      out_reg    <= pend_val;
      pend_valid <= 1'b0;
    end
  end

  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |=> $stable(out_reg)); // R10

  AST_PEND_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && pend_valid && !conv_valid) |=> (out_reg == $past(pend_val))); // R10

  AST_PEND_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && conv_valid) |=> (pend_valid && pend_val == $past(conv_data))); // R11

  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && conv_valid) |=> (out_reg == $past(conv_data) && !pend_valid)); // R9

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
  import srp_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              frame_fall,
  input  logic              sclk_level,
  input  logic              sclk_rise,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RES_W-1:0]  result,
  output logic              sdo,
  output logic              sdo_oe,
  output phase_t            phase_o
);

  localparam int WORD_W = frame_bits(ADDR_W, RES_W);
  localparam int IDX_W  = $clog2(WORD_W + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  function automatic logic [WORD_W-1:0] build_word(input logic [ADDR_W-1:0] a,
                                                   input logic [RES_W-1:0]  r);
    return {1'b0, a, r};
  endfunction

  phase_t            phase;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      word  <= '0;
    end else if (!frame_active) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else if (frame_fall) begin
      word  <= build_word(addr, result);
      idx   <= '0;
      phase <= sclk_level ? PH_SHIFT : PH_ARMED;
    end else if (sclk_rise) begin
      case (phase)
        PH_ARMED: begin
          phase <= PH_SHIFT;
          idx   <= '0;
        end
        PH_SHIFT: begin
          if (idx == LAST) phase <= PH_DONE;
          else             idx   <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign shifted = word << idx;
  assign sdo_oe  = (phase == PH_SHIFT);
  assign sdo     = sdo_oe & shifted[WORD_W-1];
  assign phase_o = phase;

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sdo == 1'b0)); // R2

  AST_STEP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !sclk_rise && frame_active) |=> ($stable(idx) && $stable(sdo))); // R3

  AST_ARMED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && !sclk_rise && frame_active) |=> !sdo_oe); // R5

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && idx == LAST && sclk_rise && frame_active) |=> !sdo_oe); // R7

  AST_OE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> !sdo_oe); // R8

endmodule

// File: rtl/result_serial_port.sv
module result_serial_port
  import srp_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              rd_frame_n,
  input  logic              conv_valid,
  input  logic [RES_W-1:0]  conv_data,
  input  logic [ADDR_W-1:0] chan_sel,
  output logic              sdo,
  output logic              sdo_oe
);

  // bit 0: serial clock, bit 1: frame (active low)
  logic [1:0] sync_level, sync_rise, sync_fall;

  // named internal events
  logic       sclk_level, sclk_rise;
  logic       frame_active, frame_start, frame_end;
  logic [RES_W-1:0] out_reg;
  logic       pend_valid;
  phase_t     phase;

  srp_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({rd_frame_n, sclk}),
    .level    (sync_level),
    .rise     (sync_rise),
    .fall     (sync_fall)
  );

  assign sclk_level   = sync_level[0];
  assign sclk_rise    = sync_rise[0];
  assign frame_active = ~sync_level[1];
  assign frame_start  = sync_fall[1];
  assign frame_end    = sync_rise[1];

  srp_result_hold #(
    .RES_W (RES_W)
  ) hold_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_valid   (conv_valid),
    .conv_data    (conv_data),
    .frame_active (frame_active),
    .out_reg      (out_reg),
    .pend_valid   (pend_valid)
  );

  srp_shifter #(
    .ADDR_W (ADDR_W),
    .RES_W  (RES_W)
  ) shift_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .frame_fall   (frame_start),
    .sclk_level   (sclk_level),
    .sclk_rise    (sclk_rise),
    .addr         (chan_sel),
    .result       (out_reg),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe),
    .phase_o      (phase)
  );

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!sdo_oe && phase == PH_IDLE)); // R8

  AST_NO_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && !conv_valid) |=> !pend_valid); // R10

endmodule

// File: tb/result_serial_port_tb_top.sv
module result_serial_port_tb_top;

  localparam int ADDR_W = 3;
  localparam int RES_W  = 12;
  localparam int SYNC   = 3;
  localparam int HALF   = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sclk;
  logic              rd_frame_n;
  logic              conv_valid;
  logic [RES_W-1:0]  conv_data;
  logic [ADDR_W-1:0] chan_sel;
  logic              sdo;
  logic              sdo_oe;

  int checks = 0;
  int errors = 0;
  logic [RES_W-1:0] model_reg;

  always #5 clk = ~clk;

  result_serial_port #(
    .ADDR_W      (ADDR_W),
    .RES_W       (RES_W),
    .SYNC_STAGES (SYNC)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .rd_frame_n (rd_frame_n),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .chan_sel   (chan_sel),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  // expected frame: zero, address, result (restated arithmetically)
  function automatic logic [15:0] expect_word(input int a, input int r);
    return 16'((a % 8) * 4096 + (r % 4096));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_conv(input logic [RES_W-1:0] v);
    conv_data  = v;
    conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic read_frame(input bit start_high, input int gap_max, input int npulse,
                            input logic [RES_W-1:0] v1, input logic [RES_W-1:0] v2,
                            input logic [15:0] exp, input string tag);
    int first;
    string t;
    sclk = start_high;
    wait_clk(HALF);
    rd_frame_n = 1'b0;
    wait_clk(HALF);
    if (start_high) begin
      check(sdo_oe && sdo == 1'b0, "R4 lead zero", {sdo_oe, sdo}, 2'b10);
      sclk = 1'b0;
      wait_clk(HALF);
      first = 1;
    end else begin
      check(!sdo_oe, "R5 idle before rise", sdo_oe, 0);
      first = 0;
    end
    t = (gap_max > 0) ? "R6 gapped bit" : tag;
    for (int i = first; i < 16; i++) begin
      if (i > 0)
        check(sdo_oe && sdo == exp[16-i], "R3 hold through low", sdo, exp[16-i]);
      sclk = 1'b1;
      wait_clk(HALF);
      if (i == 0 && !start_high)
        check(sdo_oe && sdo == 1'b0, "R5 lead zero on rise", {sdo_oe, sdo}, 2'b10);
      else
        check(sdo_oe && sdo == exp[15-i], t, {sdo_oe, sdo}, {1'b1, exp[15-i]});
      if (i == 5 && npulse >= 1) pulse_conv(v1);
      if (i == 9 && npulse >= 2) pulse_conv(v2);
      sclk = 1'b0;
      wait_clk(HALF);
      if (gap_max > 0) wait_clk(int'($urandom_range(gap_max, 0)));
    end
    sclk = 1'b1;
    wait_clk(HALF);
    check(!sdo_oe, "R7 no repeat", sdo_oe, 0);
    sclk = 1'b0;
    wait_clk(HALF);
    rd_frame_n = 1'b1;
    wait_clk(HALF);
    check(!sdo_oe, "R8 frame high", sdo_oe, 0);
    if (npulse >= 2) model_reg = v2;
    else if (npulse == 1) model_reg = v1;
  endtask

  task automatic early_end();
    sclk = 1'b0;
    wait_clk(HALF);
    rd_frame_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1;
      wait_clk(HALF);
      if (i < 3) begin
        sclk = 1'b0;
        wait_clk(HALF);
      end
    end
    rd_frame_n = 1'b1;
    wait_clk(HALF);
    check(!sdo_oe, "R8 early end", sdo_oe, 0);
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sclk = 1'b0; rd_frame_n = 1'b1;
    conv_valid = 1'b0; conv_data = '0; chan_sel = '0;
    model_reg = '0;
    wait_clk(5);
    check(!sdo_oe, "R1 reset oe", sdo_oe, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1: register is zero after reset
    chan_sel = 3'd5;
    read_frame(1'b0, 0, 0, '0, '0, expect_word(5, 0), "R1 reset word");

    // R9: idle load
    pulse_conv(12'hABC);
    model_reg = 12'hABC;
    chan_sel = 3'd2;
    read_frame(1'b0, 0, 0, '0, '0, expect_word(2, 'hABC), "R9 idle load");

    // R2/R4 start with clock high
    chan_sel = 3'd7;
    read_frame(1'b1, 0, 0, '0, '0, expect_word(7, 'hABC), "R2 word");

    // R10: deferral during frame, old value still read out
    read_frame(1'b0, 0, 1, 12'h123, '0, expect_word(7, 'hABC), "R10 held during read");
    read_frame(1'b1, 0, 0, '0, '0, expect_word(7, 'h123), "R10 applied after read");

    // R11: newest pending wins
    chan_sel = 3'd1;
    read_frame(1'b0, 0, 2, 12'h0F0, 12'h70F, expect_word(1, 'h123), "R11 held");
    read_frame(1'b0, 0, 0, '0, '0, expect_word(1, 'h70F), "R11 newest");

    // R8 early termination, then R6 gapped read
    early_end();
    read_frame(1'b1, 9, 0, '0, '0, expect_word(1, 'h70F), "R6 after early end");

    for (int it = 0; it < 36; it++) begin
      logic [ADDR_W-1:0] a;
      logic [RES_W-1:0]  w1, w2;
      int np;
      a  = ADDR_W'($urandom);
      w1 = RES_W'($urandom);
      w2 = RES_W'($urandom);
      np = int'($urandom_range(2, 0));
      chan_sel = a;
      if ($urandom_range(1, 0) == 1) begin
        pulse_conv(RES_W'($urandom));
        model_reg = conv_data;
      end
      read_frame(1'($urandom), ($urandom_range(1, 0) == 1) ? 7 : 0, np, w1, w2,
                 expect_word(int'(a), int'(model_reg)), "R2 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule